// File: doc/BRIEF.md
# Two-CPU Distributed Interrupt Controller

This block gathers interrupts of three kinds and hands each of two processors the most urgent request it may currently take. Sixteen software interrupts are raised by writing a control word that names an interrupt number and a set of destination processors. Sixteen private lines exist separately for each processor. A configurable number of shared lines can be steered to any subset of processors. Every interrupt carries an enable, a 5-bit priority (smaller number means more urgent), and pending and active state. Private and software interrupts keep their settings and state separately for each processor.

Each processor interface has a priority mask and a running priority. The running priority is the most urgent priority among the interrupts that processor holds active, or 32 when it holds none. A processor's request line is raised only for an interrupt whose priority is strictly below both its mask and its running priority, so nesting happens only when a more urgent interrupt arrives. Software reads an acknowledge register to take the interrupt, which becomes active. It then writes the identifier to an end-of-interrupt register to release it. All access goes through one synchronous read/write port, and the `reg_cpu` input tells the block which processor's banked view to use.

Top module: `dic_top`

## Requirements
- R1: After reset, both request lines are low, every enable is clear, each mask reads 32, each running priority reads 32, and an acknowledge read returns 1023.
- R2: A write to control address 0x400 with the interrupt number in bits [3:0] and a destination mask in bits [17:16] (bit 16 for processor 0) makes that software interrupt (ID 0..15) pending on every processor whose mask bit is set, and on no other.
- R3: Private line `ppi_irq[c*16+k]` is interrupt ID 16+k on processor c only. Its configuration word is banked per processor.
- R4: A shared line n is interrupt ID 32+n. It is offered only to the processors whose bits are set in bits [17:16] of its configuration word.
- R5: Configuration word at address ID: bit 0 is the enable, bit 1 shows pending (read only), bit 2 shows active (read only), bits [12:8] hold the priority and bits [17:16] hold the target mask (shared interrupts only). A disabled interrupt never raises a request.
- R6: Among eligible interrupts the smallest priority value wins. On equal priority the lower ID wins.
- R7: A processor's mask sits at control address 0x401, bits [5:0]. An interrupt is signalled only if its priority is strictly less than the mask.
- R8: A read of control address 0x402 returns the ID of the interrupt then signalled to `reg_cpu` and makes it active, clearing a software pending bit. With nothing signalled it returns 1023 and changes nothing.
- R9: A write of an ID to control address 0x403 clears that interrupt's active state for `reg_cpu`. A private or shared line still high becomes pending again.
- R10: The running priority, readable at 0x404 bits [5:0], is the smallest priority among the processor's active interrupts, or 32 when it has none. Only a strictly smaller priority preempts it.
- R11: A shared interrupt taken by one processor is offered to no processor until that processor ends it. An end-of-interrupt write for it from another processor has no effect.
- R12: A state change shows on `irq_o` one clock after the edge that made it. Read data appears on `reg_rdata` at the edge that samples `reg_re` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ppi_irq | input | N_CPU*16 | Private level lines, 16 per processor |
| spi_irq | input | N_SPI | Shared level lines |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_cpu | input | CPU_W | Processor making the access |
| reg_addr | input | 11 | Bit 10 selects control space; else interrupt ID |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | N_CPU | Registered interrupt request per processor |

## Verification
Register writes and acknowledge reads change state at the edge that samples them. The request line follows one edge later, so after every stimulus the bench lets one more falling edge pass before it reads `irq_o`. Read data is due at the edge that takes `reg_re`. The monitor therefore compares `reg_rdata` one time unit after that edge against the value the read task queued. Level inputs are moved on a falling edge, and the request is checked after the next rising edge.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int ID_W     = 10;
  localparam int N_BANKED = 32;
  localparam int N_SOFT   = 16;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  localparam int CF_EN   = 0;
  localparam int CF_PEND = 1;
  localparam int CF_ACT  = 2;
  localparam int CF_PRIO = 8;
  localparam int CF_TGT  = 16;

  typedef enum logic [2:0] {
    CTL_SOFT = 3'd0,
    CTL_MASK = 3'd1,
    CTL_ACK  = 3'd2,
    CTL_EOI  = 3'd3,
    CTL_RUN  = 3'd4
  } ctl_e;
endpackage

// File: rtl/dic_select.sv
module dic_select #(
  parameter int N  = 64,
  parameter int PW = 5,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    vld,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   best
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (!found || prio[i*PW +: PW] < best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/dic_banked.sv
module dic_banked
  import dic_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [15:0]            ppi_line,
  input  logic                   cfg_we,
  input  logic [4:0]             cfg_idx,
  input  logic [31:0]            cfg_wdata,
  input  logic [N_SOFT-1:0]      soft_set,
  input  logic [N_BANKED-1:0]    ack_set,
  input  logic [N_BANKED-1:0]    eoi_clr,
  output logic [N_BANKED-1:0]    elig,
  output logic [N_BANKED*PW-1:0] prio_flat,
  output logic [N_BANKED-1:0]    active,
  output logic [N_SOFT-1:0]      soft_pend,
  output logic [31:0]            cfg_rdata
);
  logic [N_BANKED-1:0] en_q, act_q;
  logic [N_SOFT-1:0]   spend_q;
  logic [PW-1:0]       prio_q [N_BANKED];
  logic [N_BANKED-1:0] pend_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      act_q   <= '0;
      spend_q <= '0;
      for (int i = 0; i < N_BANKED; i++) prio_q[i] <= '0;
    end else begin
      if (cfg_we) begin
        en_q[cfg_idx]   <= cfg_wdata[CF_EN];
        prio_q[cfg_idx] <= cfg_wdata[CF_PRIO +: PW];
      end
      spend_q <= (spend_q | soft_set) & ~ack_set[N_SOFT-1:0];
      act_q   <= (act_q | ack_set) & ~eoi_clr;
    end
  end

  assign pend_raw  = {ppi_line, spend_q};
  assign elig      = pend_raw & en_q & ~act_q;
  assign active    = act_q;
  assign soft_pend = spend_q;

  for (genvar g = 0; g < N_BANKED; g++) begin : g_prio
    assign prio_flat[g*PW +: PW] = prio_q[g];
  end

  always_comb begin
    cfg_rdata                 = '0;
    cfg_rdata[CF_EN]          = en_q[cfg_idx];
    cfg_rdata[CF_PEND]        = pend_raw[cfg_idx];
    cfg_rdata[CF_ACT]         = act_q[cfg_idx];
    cfg_rdata[CF_PRIO +: PW]  = prio_q[cfg_idx];
  end
endmodule

// File: rtl/dic_shared.sv
module dic_shared
  import dic_pkg::*;
#(
  parameter int NS = 32,
  parameter int NC = 2,
  parameter int PW = 5,
  localparam int CW  = (NC > 1) ? $clog2(NC) : 1,
  localparam int SIW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NS-1:0]    line,
  input  logic             cfg_we,
  input  logic [SIW-1:0]   cfg_idx,
  input  logic [31:0]      cfg_wdata,
  input  logic [NS-1:0]    ack_set,
  input  logic [CW-1:0]    ack_cpu,
  input  logic [NS-1:0]    eoi_hit,
  input  logic [CW-1:0]    eoi_cpu,
  output logic [NC*NS-1:0] offer,
  output logic [NC*NS-1:0] owned,
  output logic [NS*PW-1:0] prio_flat,
  output logic [NS-1:0]    active,
  output logic [31:0]      cfg_rdata
);
  logic [NS-1:0] en_q, act_q;
  logic [CW-1:0] own_q  [NS];
  logic [NC-1:0] tgt_q  [NS];
  logic [PW-1:0] prio_q [NS];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      act_q <= '0;
      for (int i = 0; i < NS; i++) begin
        own_q[i]  <= '0;
        tgt_q[i]  <= '0;
        prio_q[i] <= '0;
      end
    end else begin
      if (cfg_we) begin
        en_q[cfg_idx]   <= cfg_wdata[CF_EN];
        prio_q[cfg_idx] <= cfg_wdata[CF_PRIO +: PW];
        tgt_q[cfg_idx]  <= cfg_wdata[CF_TGT +: NC];
      end
      for (int i = 0; i < NS; i++) begin
        if (ack_set[i]) begin
          act_q[i] <= 1'b1;
          own_q[i] <= ack_cpu;
        end else if (eoi_hit[i] && act_q[i] && own_q[i] == eoi_cpu) begin
          act_q[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_cpu
    for (genvar i = 0; i < NS; i++) begin : g_src
      assign offer[c*NS + i] = line[i] & en_q[i] & ~act_q[i] & tgt_q[i][c];
      assign owned[c*NS + i] = act_q[i] & (own_q[i] == CW'(c));
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_prio
    assign prio_flat[g*PW +: PW] = prio_q[g];
  end

  assign active = act_q;

  always_comb begin
    cfg_rdata                = '0;
    cfg_rdata[CF_EN]         = en_q[cfg_idx];
    cfg_rdata[CF_PEND]       = line[cfg_idx];
    cfg_rdata[CF_ACT]        = act_q[cfg_idx];
    cfg_rdata[CF_PRIO +: PW] = prio_q[cfg_idx];
    cfg_rdata[CF_TGT +: NC]  = tgt_q[cfg_idx];
  end
endmodule

// File: rtl/dic_top.sv
module dic_top
  import dic_pkg::*;
#(
  parameter int N_CPU = 2,
  parameter int N_SPI = 32,
  parameter int PW    = 5,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int NCAND = N_BANKED + N_SPI,
  localparam int SELW  = $clog2(NCAND),
  localparam int SIW   = (N_SPI > 1) ? $clog2(N_SPI) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_CPU*16-1:0] ppi_irq,
  input  logic [N_SPI-1:0]    spi_irq,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [CPU_W-1:0]    reg_cpu,
  input  logic [10:0]         reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [N_CPU-1:0]    irq_o
);
  localparam logic [PW:0] RUN_IDLE = (PW+1)'(1) << PW;

  // decode
  logic            is_ctl;
  logic [ID_W-1:0] cid, eid;
  logic [2:0]      ctl;
  logic            in_bank, in_spi, eid_bank, eid_spi;
  logic [SIW-1:0]  cid_spi, eid_spi_i;

  assign is_ctl    = reg_addr[10];
  assign cid       = reg_addr[ID_W-1:0];
  assign ctl       = reg_addr[2:0];
  assign eid       = reg_wdata[ID_W-1:0];
  assign in_bank   = cid < ID_W'(N_BANKED);
  assign in_spi    = !in_bank && (cid < ID_W'(NCAND));
  assign eid_bank  = eid < ID_W'(N_BANKED);
  assign eid_spi   = !eid_bank && (eid < ID_W'(NCAND));
  assign cid_spi   = SIW'(cid - ID_W'(N_BANKED));
  assign eid_spi_i = SIW'(eid - ID_W'(N_BANKED));

  logic wr_cfg, wr_soft, wr_mask, wr_eoi, rd_ack;
  assign wr_cfg  = reg_we && !is_ctl;
  assign wr_soft = reg_we && is_ctl && ctl == CTL_SOFT;
  assign wr_mask = reg_we && is_ctl && ctl == CTL_MASK;
  assign wr_eoi  = reg_we && is_ctl && ctl == CTL_EOI;
  assign rd_ack  = reg_re && is_ctl && ctl == CTL_ACK;

  // per-processor state and selection
  logic [N_BANKED-1:0]    b_elig   [N_CPU];
  logic [N_BANKED*PW-1:0] b_prio   [N_CPU];
  logic [N_BANKED-1:0]    b_act    [N_CPU];
  logic [N_SOFT-1:0]      b_spend  [N_CPU];
  logic [31:0]            b_rd     [N_CPU];
  logic [N_BANKED-1:0]    b_ack    [N_CPU];
  logic [N_BANKED-1:0]    b_eoi    [N_CPU];
  logic [N_SOFT-1:0]      b_set    [N_CPU];
  logic                   pk_found [N_CPU];
  logic [SELW-1:0]        pk_idx   [N_CPU];
  logic [PW-1:0]          pk_prio  [N_CPU];
  logic                   rn_found [N_CPU];
  logic [SELW-1:0]        rn_idx   [N_CPU];
  logic [PW-1:0]          rn_best  [N_CPU];
  logic [PW:0]            run_prio [N_CPU];
  logic [PW:0]            mask_q   [N_CPU];
  logic [N_CPU-1:0]       sig;
  logic [N_CPU-1:0]       irq_q;

  // shared state
  logic [N_CPU*N_SPI-1:0] s_offer, s_owned;
  logic [N_SPI*PW-1:0]    s_prio;
  logic [N_SPI-1:0]       s_act, s_ack, s_eoi;
  logic [31:0]            s_rd;

  // signalled choice of the accessing processor
  logic            sel_sig;
  logic [SELW-1:0] sel_idx;
  assign sel_sig = sig[reg_cpu];
  assign sel_idx = pk_idx[reg_cpu];

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic cfg_we_c;
    assign cfg_we_c = wr_cfg && in_bank && reg_cpu == CPU_W'(c);
    assign b_set[c] = (wr_soft && reg_wdata[CF_TGT + c])
                      ? (N_SOFT'(1) << reg_wdata[3:0]) : '0;
    assign b_ack[c] = (rd_ack && sel_sig && reg_cpu == CPU_W'(c) &&
                       sel_idx < SELW'(N_BANKED))
                      ? (N_BANKED'(1) << sel_idx[4:0]) : '0;
    assign b_eoi[c] = (wr_eoi && eid_bank && reg_cpu == CPU_W'(c))
                      ? (N_BANKED'(1) << eid[4:0]) : '0;

    dic_banked #(.PW(PW)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .ppi_line  (ppi_irq[c*16 +: 16]),
      .cfg_we    (cfg_we_c),
      .cfg_idx   (cid[4:0]),
      .cfg_wdata (reg_wdata),
      .soft_set  (b_set[c]),
      .ack_set   (b_ack[c]),
      .eoi_clr   (b_eoi[c]),
      .elig      (b_elig[c]),
      .prio_flat (b_prio[c]),
      .active    (b_act[c]),
      .soft_pend (b_spend[c]),
      .cfg_rdata (b_rd[c])
    );

    dic_select #(.N(NCAND), .PW(PW)) u_pick (
      .vld   ({s_offer[c*N_SPI +: N_SPI], b_elig[c]}),
      .prio  ({s_prio, b_prio[c]}),
      .found (pk_found[c]),
      .idx   (pk_idx[c]),
      .best  (pk_prio[c])
    );

    dic_select #(.N(NCAND), .PW(PW)) u_run (
      .vld   ({s_owned[c*N_SPI +: N_SPI], b_act[c]}),
      .prio  ({s_prio, b_prio[c]}),
      .found (rn_found[c]),
      .idx   (rn_idx[c]),
      .best  (rn_best[c])
    );

    assign run_prio[c] = rn_found[c] ? {1'b0, rn_best[c]} : RUN_IDLE;
    assign sig[c] = pk_found[c] && ({1'b0, pk_prio[c]} < mask_q[c]) &&
                    ({1'b0, pk_prio[c]} < run_prio[c]);

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[c] <= RUN_IDLE;
        irq_q[c]  <= 1'b0;
      end else begin
        if (wr_mask && reg_cpu == CPU_W'(c)) mask_q[c] <= reg_wdata[PW:0];
        irq_q[c] <= sig[c];
      end
    end
  end

  assign s_ack = (rd_ack && sel_sig && sel_idx >= SELW'(N_BANKED))
                 ? (N_SPI'(1) << SIW'(sel_idx - SELW'(N_BANKED))) : '0;
  assign s_eoi = (wr_eoi && eid_spi) ? (N_SPI'(1) << eid_spi_i) : '0;

  dic_shared #(.NS(N_SPI), .NC(N_CPU), .PW(PW)) u_shared (
    .clk       (clk),
    .rst       (rst),
    .line      (spi_irq),
    .cfg_we    (wr_cfg && in_spi),
    .cfg_idx   (cid_spi),
    .cfg_wdata (reg_wdata),
    .ack_set   (s_ack),
    .ack_cpu   (reg_cpu),
    .eoi_hit   (s_eoi),
    .eoi_cpu   (reg_cpu),
    .offer     (s_offer),
    .owned     (s_owned),
    .prio_flat (s_prio),
    .active    (s_act),
    .cfg_rdata (s_rd)
  );

  // read data
  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (!is_ctl) begin
      if (in_bank)     rd_next = b_rd[reg_cpu];
      else if (in_spi) rd_next = s_rd;
    end else begin
      case (ctl)
        CTL_MASK: rd_next[PW:0]     = mask_q[reg_cpu];
        CTL_ACK:  rd_next[ID_W-1:0] = sel_sig ? ID_W'(sel_idx) : ID_NONE;
        CTL_RUN:  rd_next[PW:0]     = run_prio[reg_cpu];
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_next;
  end

  assign irq_o = irq_q;

  // flattened views for the checker
  logic [N_CPU-1:0]          chk_found;
  logic [N_CPU*PW-1:0]       chk_prio;
  logic [N_CPU*(PW+1)-1:0]   chk_mask, chk_run;
  logic [N_CPU*N_BANKED-1:0] chk_bact;
  logic [N_CPU*N_SOFT-1:0]   chk_spend;
  for (genvar c = 0; c < N_CPU; c++) begin : g_flat
    assign chk_found[c]                   = pk_found[c];
    assign chk_prio[c*PW +: PW]           = pk_prio[c];
    assign chk_mask[c*(PW+1) +: PW+1]     = mask_q[c];
    assign chk_run[c*(PW+1) +: PW+1]      = run_prio[c];
    assign chk_bact[c*N_BANKED +: N_BANKED] = b_act[c];
    assign chk_spend[c*N_SOFT +: N_SOFT]  = b_spend[c];
  end
endmodule

// File: rtl/dic_checker.sv
module dic_checker #(
  parameter int N_CPU = 2,
  parameter int N_SPI = 32,
  parameter int PW    = 5,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_we,
  input logic                reg_re,
  input logic [CPU_W-1:0]    reg_cpu,
  input logic [10:0]         reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [31:0]         reg_rdata,
  input logic [N_CPU-1:0]    irq_o,
  input logic [N_CPU-1:0]    chk_found,
  input logic [N_CPU*PW-1:0] chk_prio,
  input logic [N_CPU*(PW+1)-1:0] chk_mask,
  input logic [N_CPU*(PW+1)-1:0] chk_run,
  input logic [N_CPU*32-1:0] chk_bact,
  input logic [N_CPU*16-1:0] chk_spend
);
  AST_ACK_ID_RANGE: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr[10] && reg_addr[2:0] == 3'd2) |=>
      (reg_rdata < 32'(32 + N_SPI) || reg_rdata == 32'd1023)); // R8

  for (genvar c = 0; c < N_CPU; c++) begin : g_c
    AST_IRQ_UNDER_MASK: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] |-> $past(chk_found[c] &&
        ({1'b0, chk_prio[c*PW +: PW]} < chk_mask[c*(PW+1) +: PW+1]))); // R7

    AST_IRQ_UNDER_RUN: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] |-> $past({1'b0, chk_prio[c*PW +: PW]} <
                         chk_run[c*(PW+1) +: PW+1])); // R10

    AST_SOFT_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
      (reg_we && !reg_re && reg_addr[10] && reg_addr[2:0] == 3'd0 &&
       reg_wdata[16 + c]) |=>
        chk_spend[c*16 +: 16][$past(reg_wdata[3:0])]); // R2

    AST_EOI_CLEARS_ACT: assert property (@(posedge clk) disable iff (rst)
      (reg_we && !reg_re && reg_addr[10] && reg_addr[2:0] == 3'd3 &&
       reg_cpu == CPU_W'(c) && reg_wdata[9:0] < 10'd32) |=>
        !chk_bact[c*32 +: 32][$past(reg_wdata[4:0])]); // R9
  end
endmodule

bind dic_top dic_checker #(.N_CPU(N_CPU), .N_SPI(N_SPI), .PW(PW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_re    (reg_re),
  .reg_cpu   (reg_cpu),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .chk_found (chk_found),
  .chk_prio  (chk_prio),
  .chk_mask  (chk_mask),
  .chk_run   (chk_run),
  .chk_bact  (chk_bact),
  .chk_spend (chk_spend)
);

// File: tb/sim_dic_top.sv
module sim_dic_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NS = 32;
  localparam logic [10:0] A_SOFT = 11'h400, A_MASK = 11'h401, A_ACK = 11'h402,
                          A_EOI = 11'h403, A_RUN = 11'h404;

  logic clk = 1'b0, rst = 1'b1;
  logic [NC*16-1:0] ppi_irq = '0;
  logic [NS-1:0]    spi_irq = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [0:0]  reg_cpu = '0;
  logic [10:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] irq_o;

  int errors = 0, checks = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dic_top #(.N_CPU(NC), .N_SPI(NS), .PW(5)) u0 (
    .clk(clk), .rst(rst), .ppi_irq(ppi_irq), .spi_irq(spi_irq),
    .reg_we(reg_we), .reg_re(reg_re), .reg_cpu(reg_cpu), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  function automatic logic [31:0] cfgw(input int en, input int pr, input int tgt);
    return 32'(en) | (32'(pr) << 8) | (32'(tgt) << 16);
  endfunction

  task automatic wr(input int cpu, input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_cpu = 1'(cpu); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [10:0] a, input logic [31:0] e,
                    input string tag);
    @(negedge clk);
    reg_cpu = 1'(cpu); reg_addr = a; reg_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic chk_irq(input int c, input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq_o[c] !== e) begin
      errors++;
      $display("FAIL %s: irq_o[%0d] actual=%b expected=%b", tag, c, irq_o[c], e);
    end
  endtask

  // monitor: read data is due at the edge that samples reg_re
  always @(posedge clk) begin
    if (reg_re) begin
      #1;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12: read with no expectation, actual=%0d expected=none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s: reg_rdata actual=%0d expected=%0d", t, reg_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk_irq(0, 1'b0, "R1 reset cpu0");
    chk_irq(1, 1'b0, "R1 reset cpu1");
    rd(0, A_ACK, 32'd1023, "R1 idle ack");
    rd(1, A_RUN, 32'd32, "R1 idle running");
    rd(0, A_MASK, 32'd32, "R1 mask reset");
    rd(0, 11'd40, 32'd0, "R1 cfg reset");

    // software interrupt to cpu0 only
    wr(0, 11'd3, cfgw(1, 10, 0));
    wr(1, 11'd3, cfgw(1, 10, 0));
    wr(0, A_SOFT, 32'd3 | (32'b01 << 16));
    chk_irq(0, 1'b1, "R2 soft to cpu0");
    chk_irq(1, 1'b0, "R2 soft not cpu1");
    rd(0, 11'd3, cfgw(1, 10, 0) | 32'h2, "R5 cfg pending view");
    rd(0, A_ACK, 32'd3, "R8 ack soft");
    chk_irq(0, 1'b0, "R8 taken");
    rd(0, A_RUN, 32'd10, "R10 running after ack");
    wr(0, A_EOI, 32'd3);
    rd(0, A_RUN, 32'd32, "R9 running after eoi");

    // private lines, banked
    wr(1, 11'd20, cfgw(1, 5, 0));
    wr(0, 11'd20, cfgw(0, 5, 0));
    ppi_irq[16+4] = 1'b1;
    ppi_irq[4]    = 1'b1;
    chk_irq(1, 1'b1, "R3 private cpu1");
    chk_irq(0, 1'b0, "R5 disabled cpu0");
    rd(1, A_ACK, 32'd20, "R3 ack private");
    chk_irq(1, 1'b0, "R8 private active");
    wr(1, A_EOI, 32'd20);
    chk_irq(1, 1'b1, "R9 level repends");
    rd(1, A_ACK, 32'd20, "R9 ack again");
    ppi_irq[16+4] = 1'b0;
    ppi_irq[4]    = 1'b0;
    wr(1, A_EOI, 32'd20);
    chk_irq(1, 1'b0, "R9 released");

    // shared routing and ownership
    wr(0, 11'd40, cfgw(1, 7, 2'b10));
    spi_irq[8] = 1'b1;
    chk_irq(1, 1'b1, "R4 shared cpu1");
    chk_irq(0, 1'b0, "R4 shared not cpu0");
    wr(0, 11'd40, cfgw(1, 7, 2'b11));
    chk_irq(0, 1'b1, "R4 shared both");
    rd(0, A_ACK, 32'd40, "R11 cpu0 takes shared");
    chk_irq(1, 1'b0, "R11 withdrawn from cpu1");
    rd(1, A_ACK, 32'd1023, "R11 cpu1 gets none");
    wr(1, A_EOI, 32'd40);
    chk_irq(1, 1'b0, "R11 foreign eoi ignored");
    wr(0, A_EOI, 32'd40);
    chk_irq(1, 1'b1, "R11 offered after eoi");
    spi_irq[8] = 1'b0;
    chk_irq(1, 1'b0, "R4 line dropped");

    // priority order and preemption on cpu0
    wr(0, 11'd5,  cfgw(1, 12, 0));
    wr(0, 11'd33, cfgw(1, 12, 2'b01));
    wr(0, 11'd34, cfgw(1, 4, 2'b01));
    wr(0, A_SOFT, 32'd5 | (32'b01 << 16));
    spi_irq[1] = 1'b1;
    rd(0, A_ACK, 32'd5, "R6 tie lower id");
    chk_irq(0, 1'b0, "R10 equal no preempt");
    spi_irq[2] = 1'b1;
    chk_irq(0, 1'b1, "R10 preempt");
    rd(0, A_ACK, 32'd34, "R6 urgent wins");
    rd(0, A_RUN, 32'd4, "R10 nested running");
    spi_irq[2] = 1'b0;
    wr(0, A_EOI, 32'd34);
    rd(0, A_RUN, 32'd12, "R10 running back");
    chk_irq(0, 1'b0, "R10 still blocked");
    wr(0, A_EOI, 32'd5);
    chk_irq(0, 1'b1, "R9 shared now due");
    rd(0, A_ACK, 32'd33, "R6 remaining");
    spi_irq[1] = 1'b0;
    wr(0, A_EOI, 32'd33);

    // priority mask
    wr(0, A_MASK, 32'd12);
    wr(0, A_SOFT, 32'd5 | (32'b01 << 16));
    chk_irq(0, 1'b0, "R7 equal to mask blocked");
    rd(0, A_ACK, 32'd1023, "R7 masked ack");
    wr(0, A_MASK, 32'd13);
    chk_irq(0, 1'b1, "R7 below mask");
    rd(0, A_MASK, 32'd13, "R7 mask readback");
    rd(0, A_ACK, 32'd5, "R8 ack after unmask");
    wr(0, A_EOI, 32'd5);
    chk_irq(0, 1'b0, "R12 quiet at end");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule